// File: doc/BRIEF.md
# Supervisory Reset Timer Controller

This block produces a system reset from two sources: a digital supply-good flag and a reset pin that both carries the reset out and accepts a push-button pulse in. Reset goes active while the supply is reported low. After the supply recovers, reset is held for a fixed stretch interval and then released. A press on the reset pin from outside is filtered for glitches, detected on its leading edge, and turned into a reset of full stretch length, however short the press was.

The supply flag is assumed to be already synchronized to `clk`, and so is the sensed level of the pin. The pin is open-drain. The block returns a drive enable, which is high only while reset is active, and a reset level whose polarity a parameter selects. The stretch interval and both glitch filters are given in clock cycles. Their defaults come from a clock-frequency parameter: about 200 ms for the stretch, about 100 ns for the pin filter and about 1 us for the supply filter. A bench can therefore scale them down.

Top module: `sup_reset_ctrl`

## Requirements
- R1: When `supply_ok_i` is sampled low on SUP_FILT_CYC consecutive edges, `pin_drive_o` is high from the next edge on. It stays high for as long as the flag stays low.
- R2: A low run of `supply_ok_i` that covers fewer than SUP_FILT_CYC consecutive edges leaves `pin_drive_o` low.
- R3: Once the supply flag returns high after a reset it caused, `pin_drive_o` goes low on the (TIMEOUT_CYC+1)-th edge. The first edge that samples `supply_ok_i` high counts as edge one.
- R4: While `rst_n` is low, `pin_drive_o` is high. After `rst_n` returns high, it goes low on the TIMEOUT_CYC-th edge, provided the supply flag is high.
- R5: The pin is at its active level when it is 0 for ACTIVE_HIGH=0 and 1 for ACTIVE_HIGH=1. Suppose the block is not driving and `pin_i` has been sampled inactive. If `pin_i` is then sampled active on MAN_FILT_CYC consecutive edges, `pin_drive_o` goes high on edge MAN_FILT_CYC+1 and stays high for exactly TIMEOUT_CYC cycles.
- R6: An active run on `pin_i` that covers fewer than MAN_FILT_CYC edges starts no reset.
- R7: An external press of any length gives a reset of exactly TIMEOUT_CYC cycles. A pin still held active after that release starts no further reset until it has been sampled inactive, and the next press does start one.
- R8: While reset is active, `rst_level_o` equals the active level. At all other times it holds the opposite level, and `pin_drive_o` is low.
- R9: The block's own drive on the pin is never taken as a press. A reset the block asserted, with the pin held active by that drive for longer than MAN_FILT_CYC cycles, is followed by no further reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low local reset |
| supply_ok_i | input | 1 | Synchronized flag, high while the supply is above threshold |
| pin_i | input | 1 | Synchronized sensed level of the reset pin |
| pin_drive_o | output | 1 | Open-drain enable, high while reset is active |
| rst_level_o | output | 1 | Reset level in the selected polarity |

## Verification
If the stretch counter is off by one, the release edge of `pin_drive_o` moves by a cycle. This shows at the end of every reset, whatever its cause: the first release after local reset, at TIMEOUT_CYC cycles, already exposes it. If a filter count is wrong, a run exactly one cycle shorter than the threshold is either let through or a run at the threshold is rejected. Either mistake shows within MAN_FILT_CYC+1 or SUP_FILT_CYC+1 cycles of the stimulus. If the arming state is stuck, the block either retriggers on its own drive or on a held pin, which shows as a second reset right after release. It may instead miss a later press, which shows as no reset at all.

// File: rtl/sup_rst_pkg.sv
// Package: shared types and sizing helpers for the supervisory reset controller.
// Assumes: counts passed to the helpers are at least 1.
package sup_rst_pkg;

    // Stretch-timer state: released, held by a bad supply, or counting the stretch.
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } tmr_state_t;

    // Width of a counter that must hold the values 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Clamp a derived count so that it is never below one cycle.
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sup_supply_filter.sv
// Module: rejects short low glitches on the supply-good flag.
// Does: raises bad_o once supply_ok_i has been sampled low on FILT_CYC
//       consecutive edges; clears it on the first high sample.
// Assumes: supply_ok_i is already synchronous to clk.
module sup_supply_filter
    import sup_rst_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic bad_o
);
    localparam int CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] low_cnt_q;
    logic          bad_q;

    // Count consecutive low samples and flag a bad supply at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            bad_q     <= 1'b0;
        end else if (supply_ok_i) begin
            low_cnt_q <= '0;
            bad_q     <= 1'b0;
        end else if (low_cnt_q == LAST) begin
            bad_q     <= 1'b1;
        end else begin
            low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    assign bad_o = bad_q;

    // R2: a bad indication only ever starts from a low sample.
    p_glitch_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_o) |-> $past(!supply_ok_i));

    // R3: a high sample clears the bad indication on the next edge.
    p_recover_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok_i |=> !bad_o);

endmodule

// File: rtl/sup_manual_detect.sv
// Module: detects an external press on the shared reset pin.
// Does: emits a one-cycle trig_o after the pin has been seen active for
//       FILT_CYC consecutive samples. This happens only if it was seen
//       inactive before the run, and only while the block is not driving it.
// Assumes: pin_i is synchronous to clk; driving_i is the block's own drive enable.
module sup_manual_detect
    import sup_rst_pkg::*;
#(
    parameter int FILT_CYC    = 2,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic driving_i,
    output logic trig_o
);
    localparam int CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
    localparam logic ACT_LVL = ACTIVE_HIGH;

    logic          pin_act;
    logic          armed_q;
    logic [CW-1:0] run_cnt_q;
    logic          trig_q;

    // Decode the pin level against the selected polarity.
    assign pin_act = (pin_i == ACT_LVL);

    // Arm on an inactive sample, count an active run, fire once per press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            run_cnt_q <= '0;
            trig_q    <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (driving_i) begin
                armed_q   <= 1'b0;
                run_cnt_q <= '0;
            end else if (!pin_act) begin
                armed_q   <= 1'b1;
                run_cnt_q <= '0;
            end else if (armed_q) begin
                if (run_cnt_q == LAST) begin
                    trig_q    <= 1'b1;
                    armed_q   <= 1'b0;
                    run_cnt_q <= '0;
                end else begin
                    run_cnt_q <= run_cnt_q + CW'(1);
                end
            end
        end
    end

    assign trig_o = trig_q;

    // R5: a press yields a single-cycle trigger.
    p_single_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R6: a trigger is preceded by an active pin sample.
    p_trig_needs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(pin_act));

endmodule

// File: rtl/sup_stretch_timer.sv
// Module: holds reset while the supply is bad and stretches every reset
//         to TIMEOUT_CYC cycles.
// Does: a bad supply parks the timer in HOLD at count zero; a start pulse
//       restarts the stretch; the timer releases when the count reaches its end.
// Assumes: hold_i and start_i are registered in clk's domain.
module sup_stretch_timer
    import sup_rst_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    tmr_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // Advance the reset state: hold beats start, start beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STRETCH;
            cnt_q   <= '0;
        end else if (hold_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_STRETCH;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_HOLD, ST_STRETCH: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_OFF;
                        cnt_q   <= '0;
                    end else begin
                        state_q <= ST_STRETCH;
                        cnt_q   <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_q <= ST_OFF;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign active_o = (state_q != ST_OFF);

    // R1: a bad supply forces reset active on the next edge.
    p_hold_forces_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> active_o);

    // R5: a start pulse restarts the stretch from zero.
    p_start_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !hold_i) |=> (state_q == ST_STRETCH && cnt_q == '0));

    // R7: release happens only after the full count.
    p_full_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> ($past(cnt_q) == LAST));

    // R3: the counter never runs past its end value.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/sup_reset_ctrl.sv
// Module: top of the supervisory reset controller.
// Does: combines the supply glitch filter, the pin press detector and the
//       stretch timer; drives an open-drain enable and a polarity-selected level.
// Assumes: supply_ok_i and pin_i are synchronized; the pin's pull resistor
//          returns it to the inactive level when not driven.
module sup_reset_ctrl
    import sup_rst_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int TIMEOUT_CYC  = at_least_one(CLK_HZ / 5),
    parameter int MAN_FILT_CYC = at_least_one((CLK_HZ + 9_999_999) / 10_000_000),
    parameter int SUP_FILT_CYC = at_least_one(CLK_HZ / 1_000_000),
    parameter bit ACTIVE_HIGH  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic pin_i,
    output logic pin_drive_o,
    output logic rst_level_o
);
    localparam logic ACT_LVL = ACTIVE_HIGH;

    logic sup_bad;
    logic man_trig;
    logic rst_active;

    sup_supply_filter #(
        .FILT_CYC (SUP_FILT_CYC)
    ) u_supply (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .bad_o       (sup_bad)
    );

    sup_manual_detect #(
        .FILT_CYC    (MAN_FILT_CYC),
        .ACTIVE_HIGH (ACTIVE_HIGH)
    ) u_manual (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .driving_i (rst_active),
        .trig_o    (man_trig)
    );

    sup_stretch_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (sup_bad),
        .start_i  (man_trig),
        .active_o (rst_active)
    );

    // Drive the pin only while reset is active; present the level in the chosen polarity.
    assign pin_drive_o = rst_active;
    assign rst_level_o = rst_active ? ACT_LVL : ~ACT_LVL;

    // R8: the level output agrees with the drive enable in the chosen polarity.
    p_level_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_level_o == ACT_LVL) == pin_drive_o);

    // R3: reset is only released when the supply was not flagged bad.
    p_release_needs_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_drive_o) |-> $past(!sup_bad));

endmodule

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
    localparam int T  = 40;
    localparam int MF = 4;
    localparam int SF = 3;
    localparam int NV = 8;
    // kind (0 supply low run, 1 pin press), run length, expected active cycles, requirement
    localparam int VEC [NV][4] = '{
        '{0, 2, 0,     2},
        '{0, 1, 0,     2},
        '{0, 3, T,     3},
        '{0, 7, T + 4, 3},
        '{1, 3, 0,     6},
        '{1, 1, 0,     6},
        '{1, 4, T,     5},
        '{1, 10, T,    7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic ext_a = 1'b1;
    logic ext_b = 1'b0;
    logic drv_a, lvl_a, drv_b, lvl_b;
    logic pin_a, pin_b;
    int   nchk = 0;
    int   nerr = 0;
    int   cyc  = 0;

    always #2 clk = ~clk;

    assign pin_a = drv_a ? 1'b0 : ext_a;
    assign pin_b = drv_b ? 1'b1 : ext_b;

    sup_reset_ctrl #(.TIMEOUT_CYC(T), .MAN_FILT_CYC(MF), .SUP_FILT_CYC(SF),
                     .ACTIVE_HIGH(1'b0)) i_sup_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .pin_i(pin_a),
        .pin_drive_o(drv_a), .rst_level_o(lvl_a));

    sup_reset_ctrl #(.TIMEOUT_CYC(T), .MAN_FILT_CYC(MF), .SUP_FILT_CYC(SF),
                     .ACTIVE_HIGH(1'b1)) i_sup_reset_ctrl_hi (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .pin_i(pin_b),
        .pin_drive_o(drv_b), .rst_level_o(lvl_b));

    function automatic string req_name(input int r);
        case (r)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count edges until the chosen drive enable reaches the wanted level.
    task automatic wait_for(input int which, input logic want, output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while ((((which == 0) ? drv_a : drv_b) !== want) && k < 2000);
    endtask

    // Count sampled active cycles of drv_a over n edges.
    task automatic count_high(input int n, inout int acc);
        for (int i = 0; i < n; i++) begin
            tick();
            if (drv_a) acc++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int k;
        int acc;
        // Reset state (R4, R8)
        tick(); tick(); tick();
        check_eq("R4", drv_a, 1);
        check_eq("R8", lvl_a, 0);
        check_eq("R8", lvl_b, 1);
        // Release after local reset (R4)
        rst_n = 1'b1;
        wait_for(0, 1'b0, k);
        check_eq("R4", k, T);
        check_eq("R8", lvl_a, 1);
        check_eq("R8", lvl_b, 0);
        // Own drive held the pin low for T cycles: no retrigger (R9)
        acc = 0;
        count_high(2 * T, acc);
        check_eq("R9", acc, 0);

        // Vector table
        for (int r = 0; r < NV; r++) begin
            acc = 0;
            for (int i = 0; i < VEC[r][1]; i++) begin
                if (VEC[r][0] == 0) supply_ok = 1'b0;
                else ext_a = 1'b0;
                tick();
                if (drv_a) acc++;
            end
            supply_ok = 1'b1;
            ext_a = 1'b1;
            count_high(T + 20, acc);
            check_eq(req_name(VEC[r][3]), acc, VEC[r][2]);
        end

        // R1: latency of a supply drop and hold while low
        supply_ok = 1'b0;
        wait_for(0, 1'b1, k);
        check_eq("R1", k, SF + 1);
        count_high(50, acc);
        check_eq("R1", drv_a, 1);
        // R3: release after recovery
        supply_ok = 1'b1;
        wait_for(0, 1'b0, k);
        check_eq("R3", k, T + 1);
        count_high(5, acc);

        // R5: latency of a press
        ext_a = 1'b0;
        for (int i = 0; i < MF; i++) tick();
        ext_a = 1'b1;
        wait_for(0, 1'b1, k);
        check_eq("R5", k, 1);
        wait_for(0, 1'b0, k);
        check_eq("R5", k, T);
        count_high(5, acc);

        // R7: pin held past release does not retrigger; later press does
        ext_a = 1'b0;
        acc = 0;
        count_high(3 * T, acc);
        check_eq("R7", acc, T);
        check_eq("R7", drv_a, 0);
        ext_a = 1'b1;
        tick(); tick();
        ext_a = 1'b0;
        wait_for(0, 1'b1, k);
        check_eq("R7", k, MF + 1);
        ext_a = 1'b1;
        count_high(T + 10, acc);
        check_eq("R7", drv_a, 0);

        // R8: active-high variant reacts to a high press
        ext_b = 1'b1;
        wait_for(1, 1'b1, k);
        check_eq("R8", k, MF + 1);
        check_eq("R8", lvl_b, 1);
        ext_b = 1'b0;
        wait_for(1, 1'b0, k);
        check_eq("R8", k, T);
        check_eq("R8", lvl_b, 0);
        check_eq("R8", lvl_a, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule